// File: doc/BRIEF.md
# DDS Phase Accumulator Core

This block is the phase path of a direct digital synthesizer. On every system clock an accumulator grows by an unsigned frequency word and wraps at its width. A phase offset is then added to the top bits of the accumulator. The result is a truncated phase word that a later cosine lookup stage turns into an amplitude.

Frequency and offset writes go into staging registers only. They take effect together on a synchronous update strobe, so a controller can change both without an output glitch in between. The accumulator can be cleared in two ways. One control holds it at zero for as long as it is set. The other clears it once, on the update strobe, and then lets it run again, so a new tone can start from a known phase.

Top module: `dds_phase_core`

## Requirements
- R1: After the synchronous active-low reset, the accumulator, the active and staged frequency words and the active and staged offsets are all zero. The phase output stays zero on the following clocks until an update is issued.
- R2: On every clock edge with no clear, the accumulator adds the active frequency word modulo 2^ACC_W. With ACC_W=32 and PHASE_W=14, a word of 0x01000000 raises the phase output by 0x40 per clock.
- R3: The phase output equals the top PHASE_W bits of the accumulator plus the active offset, modulo 2^PHASE_W. For example, an offset of 0x3FFF plus a top-bits value of 1 gives 0.
- R4: A frequency word of 0x80000000 makes the phase output alternate between 0 and 0x2000. A word of 0xC0000000 aliases to a downward step: 0x3000, 0x2000, 0x1000, 0.
- R5: With ACC_W=3 and a frequency word of 1, the accumulator steps through 0 to 7 and returns to 0 on the eighth clock.
- R6: Writing a frequency or offset word changes nothing at the output until an update. On the update edge the accumulator still adds the previous word, and the new word applies from the next clock.
- R7: While the hold-clear control is high, the accumulator is zero after every clock, so the phase output equals the offset. When the control is released, accumulation resumes from zero.
- R8: An update with the clear-on-update control high zeroes the accumulator on that edge. The newly loaded frequency word is then added from the next clock.
- R9: The clear-on-update control has no effect on clocks without an update strobe.
- R10: When a write and an update fall in the same cycle, the update activates the value that was staged before that edge. The value written in that cycle waits for the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ftw_wr | input | 1 | Write strobe for the staged frequency word |
| ftw_wdata | input | ACC_W | Frequency word to stage |
| pow_wr | input | 1 | Write strobe for the staged phase offset |
| pow_wdata | input | PHASE_W | Phase offset to stage |
| update | input | 1 | Copies the staged words into the active registers |
| clr_hold | input | 1 | Holds the accumulator at zero while high |
| clr_on_update | input | 1 | Clears the accumulator once on each update |
| phase_out | output | PHASE_W | Truncated phase word with offset applied |

## Verification
The bench builds two copies of the block.

The first copy uses the default widths, ACC_W=32 and PHASE_W=14. It reaches the Nyquist and aliased frequency words, the wrap of the offset sum at 14 bits, and the timing of staged writes against updates and clears.

The second copy uses ACC_W=3 and PHASE_W=3. This makes the phase output equal to the whole accumulator, so a complete accumulator wrap can be seen at the output within eight clocks.

// File: rtl/dds_phase_pkg.sv
// Shared types for the DDS phase path.
// Assumes: nothing beyond being compiled before the modules that use it.
package dds_phase_pkg;

    // What the accumulator does on the next clock edge.
    typedef enum logic [1:0] {
        ACC_RUN   = 2'd0,  // add the active frequency word
        ACC_HOLD  = 2'd1,  // continuous clear, stay at zero
        ACC_SNAP  = 2'd2   // one-shot clear at an update
    } acc_op_e;

endpackage

// File: rtl/dds_stage_reg.sv
// Staged register pair: a write lands in the staging register and an update
// copies the staging register into the active register.
// Assumes: an update copies the staged value as it stood before the edge,
// so a write in the same cycle only reaches the staging register.
module dds_stage_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    output logic [W-1:0] staged_q,
    output logic [W-1:0] active_q
);

    // Capture the written value into the staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= '0;
        end else if (wr_en) begin
            staged_q <= wr_data;
        end
    end

    // Move the staged value into the active register on an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (load) begin
            active_q <= staged_q;
        end
    end

endmodule

// File: rtl/dds_clear_ctrl.sv
// Decodes the two clear controls and the update strobe into one
// accumulator operation.
// Assumes: the continuous clear takes priority over the one-shot clear.
module dds_clear_ctrl
    import dds_phase_pkg::*;
(
    input  logic    clr_hold,
    input  logic    clr_on_update,
    input  logic    update,
    output acc_op_e acc_op
);

    // Pick the accumulator operation for this cycle.
    always_comb begin
        if (clr_hold) begin
            acc_op = ACC_HOLD;
        end else if (clr_on_update && update) begin
            acc_op = ACC_SNAP;
        end else begin
            acc_op = ACC_RUN;
        end
    end

endmodule

// File: rtl/dds_accumulator.sv
// Phase accumulator: modulo-2^ACC_W sum of the frequency word, with clear.
// Assumes: step is the active frequency word, stable between updates.
module dds_accumulator
    import dds_phase_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_op_e          acc_op,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_q
);

    // Advance, hold at zero, or clear once, as the operation selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            unique case (acc_op)
                ACC_HOLD: acc_q <= '0;
                ACC_SNAP: acc_q <= '0;
                default:  acc_q <= acc_q + step;
            endcase
        end
    end

endmodule

// File: rtl/dds_phase_adder.sv
// Truncates the accumulator to its top PHASE_W bits and adds the offset,
// modulo 2^PHASE_W.
// Assumes: PHASE_W <= ACC_W.
module dds_phase_adder #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 14
) (
    input  logic [ACC_W-1:0]   acc,
    input  logic [PHASE_W-1:0] offset,
    output logic [PHASE_W-1:0] phase
);

    localparam int DROP_W = ACC_W - PHASE_W;

    logic [PHASE_W-1:0] acc_top;

    // Choose the truncation variant for the configured widths.
    generate
        if (DROP_W == 0) begin : g_full
            assign acc_top = acc;
        end else begin : g_trunc
            assign acc_top = acc[ACC_W-1:DROP_W];
        end
    endgenerate

    // Add the offset; the carry out of the top bit is dropped.
    always_comb begin
        phase = acc_top + offset;
    end

endmodule

// File: rtl/dds_phase_core.sv
// DDS phase path top: staged frequency and offset words, a clear controller,
// the phase accumulator and the offset adder.
// Assumes: all inputs are synchronous to clk; update is a single-cycle strobe.
module dds_phase_core
    import dds_phase_pkg::*;
#(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ftw_wr,
    input  logic [ACC_W-1:0]   ftw_wdata,
    input  logic               pow_wr,
    input  logic [PHASE_W-1:0] pow_wdata,
    input  logic               update,
    input  logic               clr_hold,
    input  logic               clr_on_update,
    output logic [PHASE_W-1:0] phase_out
);

    logic [ACC_W-1:0]   ftw_shd;
    logic [ACC_W-1:0]   ftw_act;
    logic [PHASE_W-1:0] pow_shd;
    logic [PHASE_W-1:0] pow_act;
    logic [ACC_W-1:0]   acc_q;
    acc_op_e            acc_op;

    // Staged and active frequency word.
    dds_stage_reg #(.W(ACC_W)) u_ftw (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ftw_wr),
        .wr_data  (ftw_wdata),
        .load     (update),
        .staged_q (ftw_shd),
        .active_q (ftw_act)
    );

    // Staged and active phase offset.
    dds_stage_reg #(.W(PHASE_W)) u_pow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pow_wr),
        .wr_data  (pow_wdata),
        .load     (update),
        .staged_q (pow_shd),
        .active_q (pow_act)
    );

    // Decode the clear modes.
    dds_clear_ctrl u_clr (
        .clr_hold      (clr_hold),
        .clr_on_update (clr_on_update),
        .update        (update),
        .acc_op        (acc_op)
    );

    // Phase accumulator.
    dds_accumulator #(.ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_op (acc_op),
        .step   (ftw_act),
        .acc_q  (acc_q)
    );

    // Offset and truncation.
    dds_phase_adder #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_add (
        .acc    (acc_q),
        .offset (pow_act),
        .phase  (phase_out)
    );

endmodule

// File: rtl/dds_phase_core_chk.sv
// Assertion checker for dds_phase_core, attached by bind below.
// Assumes: it sees the internal accumulator and staging registers by name.
module dds_phase_core_chk #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               update,
    input logic               clr_hold,
    input logic               clr_on_update,
    input logic [ACC_W-1:0]   ftw_shd,
    input logic [ACC_W-1:0]   ftw_act,
    input logic [PHASE_W-1:0] pow_shd,
    input logic [PHASE_W-1:0] pow_act,
    input logic [ACC_W-1:0]   acc_q
);

    // R1: reset clears the accumulator and the active words.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0 && ftw_act == '0 && pow_act == '0));

    // R2: without a clear, the accumulator advances by the active word.
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hold && !(clr_on_update && update))
        |=> acc_q == $past(acc_q) + $past(ftw_act));

    // R7: continuous clear leaves the accumulator at zero.
    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hold |=> acc_q == '0);

    // R8: a clearing update zeroes the accumulator.
    a_r8_snap_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (update && clr_on_update) |=> acc_q == '0);

    // R6: active words change only at an update.
    a_r6_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !update |=> ($stable(ftw_act) && $stable(pow_act)));

    // R10: an update takes the value staged before its edge.
    a_r10_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
        update |=> (ftw_act == $past(ftw_shd) && pow_act == $past(pow_shd)));

endmodule

bind dds_phase_core dds_phase_core_chk #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .update        (update),
    .clr_hold      (clr_hold),
    .clr_on_update (clr_on_update),
    .ftw_shd       (ftw_shd),
    .ftw_act       (ftw_act),
    .pow_shd       (pow_shd),
    .pow_act       (pow_act),
    .acc_q         (acc_q)
);

// File: tb/dds_phase_core_test.sv
// Directed bench for dds_phase_core: one default-width copy and one 3-bit copy.
module dds_phase_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ftw_wr = 1'b0;
    logic [31:0] ftw_wdata = '0;
    logic        pow_wr = 1'b0;
    logic [13:0] pow_wdata = '0;
    logic        update = 1'b0;
    logic        clr_hold = 1'b0;
    logic        clr_on_update = 1'b0;
    logic [13:0] phase;
    logic [2:0]  s_ftw_wdata = '0;
    logic [2:0]  s_pow_wdata = '0;
    logic [2:0]  s_phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dds_phase_core #(.ACC_W(32), .PHASE_W(14)) uut (
        .clk (clk), .rst_n (rst_n),
        .ftw_wr (ftw_wr), .ftw_wdata (ftw_wdata),
        .pow_wr (pow_wr), .pow_wdata (pow_wdata),
        .update (update), .clr_hold (clr_hold),
        .clr_on_update (clr_on_update), .phase_out (phase)
    );

    dds_phase_core #(.ACC_W(3), .PHASE_W(3)) uut3 (
        .clk (clk), .rst_n (rst_n),
        .ftw_wr (ftw_wr), .ftw_wdata (s_ftw_wdata),
        .pow_wr (pow_wr), .pow_wdata (s_pow_wdata),
        .update (update), .clr_hold (clr_hold),
        .clr_on_update (clr_on_update), .phase_out (s_phase)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ftw_wr = 1'b0; pow_wr = 1'b0; update = 1'b0;
        clr_hold = 1'b0; clr_on_update = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic write_ftw(input logic [31:0] v);
        ftw_wr = 1'b1; ftw_wdata = v;
        tick();
        ftw_wr = 1'b0;
    endtask

    task automatic write_pow(input logic [13:0] v);
        pow_wr = 1'b1; pow_wdata = v;
        tick();
        pow_wr = 1'b0;
    endtask

    task automatic pulse_update();
        update = 1'b1;
        tick();
        update = 1'b0;
    endtask

    // R1: reset state, and reset after activity.
    task automatic t_reset();
        do_reset();
        chk("R1 phase after reset", 32'(phase), 32'h0);
        write_ftw(32'h0100_0000);
        write_pow(14'h0123);
        pulse_update();
        tick();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R1 active words cleared", 32'(phase), 32'h0);
        end
    endtask

    // R6 and R2: staged writes wait for update; steady advance.
    task automatic t_staging();
        do_reset();
        write_ftw(32'h0100_0000);
        for (int i = 0; i < 3; i++) tick();
        chk("R6 no effect before update", 32'(phase), 32'h0);
        pulse_update();
        chk("R6 old word on update edge", 32'(phase), 32'h0);
        tick();
        chk("R2 first step", 32'(phase), 32'h40);
        tick();
        chk("R2 second step", 32'(phase), 32'h80);
        write_pow(14'h0005);
        chk("R6 offset waits", 32'(phase), 32'hC0);
        pulse_update();
        chk("R3 offset applied", 32'(phase), 32'h105);
    endtask

    // R3: offset sum wraps at PHASE_W.
    task automatic t_offset_wrap();
        do_reset();
        write_ftw(32'h0004_0000);
        write_pow(14'h3FFF);
        pulse_update();
        chk("R3 offset only", 32'(phase), 32'h3FFF);
        tick();
        chk("R3 sum wraps", 32'(phase), 32'h0);
    endtask

    // R4: Nyquist word and an aliased word.
    task automatic t_nyquist();
        do_reset();
        write_ftw(32'h8000_0000);
        pulse_update();
        chk("R4 nyquist start", 32'(phase), 32'h0);
        tick(); chk("R4 nyquist half", 32'(phase), 32'h2000);
        tick(); chk("R4 nyquist back", 32'(phase), 32'h0);
        tick(); chk("R4 nyquist half again", 32'(phase), 32'h2000);
        do_reset();
        write_ftw(32'hC000_0000);
        pulse_update();
        tick(); chk("R4 alias step1", 32'(phase), 32'h3000);
        tick(); chk("R4 alias step2", 32'(phase), 32'h2000);
        tick(); chk("R4 alias step3", 32'(phase), 32'h1000);
        tick(); chk("R4 alias step4", 32'(phase), 32'h0);
    endtask

    // R7: continuous clear.
    task automatic t_hold_clear();
        do_reset();
        write_ftw(32'h0004_0000);
        write_pow(14'h0010);
        pulse_update();
        chk("R7 setup", 32'(phase), 32'h10);
        tick(); tick();
        chk("R7 running", 32'(phase), 32'h12);
        clr_hold = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7 held at offset", 32'(phase), 32'h10);
        end
        clr_hold = 1'b0;
        tick(); chk("R7 released", 32'(phase), 32'h11);
        tick(); chk("R7 running again", 32'(phase), 32'h12);
    endtask

    // R8 and R9: one-shot clear on update.
    task automatic t_snap_clear();
        do_reset();
        write_ftw(32'h0004_0000);
        pulse_update();
        for (int i = 0; i < 5; i++) tick();
        chk("R8 before", 32'(phase), 32'h5);
        write_ftw(32'h0008_0000);
        chk("R6 staged write during run", 32'(phase), 32'h6);
        clr_on_update = 1'b1;
        update = 1'b1;
        tick();
        update = 1'b0;
        chk("R8 cleared on update", 32'(phase), 32'h0);
        tick(); chk("R8 new word from next clock", 32'(phase), 32'h2);
        tick(); chk("R9 no clear without update", 32'(phase), 32'h4);
        tick(); chk("R9 still running", 32'(phase), 32'h6);
        clr_on_update = 1'b0;
    endtask

    // R10: write and update in the same cycle.
    task automatic t_same_cycle();
        do_reset();
        write_ftw(32'h0004_0000);
        ftw_wr = 1'b1; ftw_wdata = 32'h0010_0000; update = 1'b1;
        tick();
        ftw_wr = 1'b0; update = 1'b0;
        chk("R10 update edge", 32'(phase), 32'h0);
        tick(); chk("R10 old staged word active", 32'(phase), 32'h1);
        tick(); chk("R10 old staged word again", 32'(phase), 32'h2);
        pulse_update();
        chk("R10 second update edge", 32'(phase), 32'h3);
        tick(); chk("R10 late word active", 32'(phase), 32'h7);
    endtask

    // R5: full wrap of a 3-bit accumulator.
    task automatic t_small_wrap();
        do_reset();
        s_ftw_wdata = 3'd1;
        ftw_wdata = '0;
        ftw_wr = 1'b1;
        tick();
        ftw_wr = 1'b0;
        pulse_update();
        chk("R5 start", 32'(s_phase), 32'h0);
        for (int i = 1; i <= 8; i++) begin
            tick();
            chk("R5 step", 32'(s_phase), 32'(i % 8));
        end
        s_ftw_wdata = '0;
    endtask

    initial begin
        t_reset();
        t_staging();
        t_offset_wrap();
        t_nyquist();
        t_hold_clear();
        t_snap_clear();
        t_same_cycle();
        t_small_wrap();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule